// File: doc/BRIEF.md
# Interrupt Event Latch and Enable Mask

This block is the interrupt register group of a bus controller. Single-cycle event pulses from the transfer engine are captured in a sticky status register. Each status bit stays set until software writes a one to it. A separate enable mask chooses which pending events may raise the single level interrupt line.

Software never writes the mask as a whole. One write-only offset turns mask bits on and another turns them off, so two agents can change their own bits without a read-modify-write race. A read-only offset returns the current mask. The event and mask vectors are ten bits wide, and one position is reserved and never holds state. A second output shows, without regard to the mask, whether any event of the error class is pending.

Access is through a simple register port of four word offsets. Writes take effect at the clock edge. Read data is combinational from the selected offset.

Top module: `evt_irq_regs`

## Requirements
- R1: After reset the status register, the mask and the `irq` output are all zero.
- R2: An event pulse on bit i of `evt_i` sets status bit i at the next clock edge, whether or not mask bit i is set. Bit positions: 0 transfer done, 1 data level, 2 no-acknowledge, 3 timeout, 4 target ready, 5 receive overflow, 6 transmit overflow, 7 receive underflow, 9 arbitration lost.
- R3: A write to word offset 0 (status) clears exactly the status bits written as one and leaves all other bits unchanged.
- R4: When an event pulse and a status clear hit the same bit in the same cycle, the bit ends up set.
- R5: A write to word offset 2 (enable) sets the mask bits written as one and leaves the other mask bits unchanged. The offset reads as zero.
- R6: A write to word offset 3 (disable) clears the mask bits written as one and leaves the other mask bits unchanged. The offset reads as zero.
- R7: Word offset 1 returns the mask, and a write to it has no effect on the mask or the status.
- R8: `irq` equals the OR over all bits of (status AND mask) as it stood one clock earlier.
- R9: Bit 8 is reserved. It reads as zero in both status and mask, even after an event on bit 8 or an enable write of one to bit 8.
- R10: `err_any` is high exactly when at least one of status bits 2, 5, 6, 7 or 9 is set, independent of the mask.
- R11: Bits 31 down to 10 of `bus_rdata` always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 10 | Event pulses from the transfer engine, one per status bit |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Word offset: 0 status, 1 mask view, 2 enable, 3 disable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the offset on `bus_addr` |
| irq | output | 1 | Level interrupt, registered |
| err_any | output | 1 | Any error-class status bit pending |

## Verification
A lost or stuck status bit shows on the status readback right after the edge that should have changed it, and one cycle later on `irq` if that bit is enabled. A mask bit flipped by the wrong strobe shows at once on the mask view offset, and on `irq` the cycle after any matching event is pending. A set/clear priority error appears only when both hit the same bit together, so that case is driven directly and is also hit many times by the random mix. A decode error that lets a write reach the mask view offset shows on the next readback of the mask.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   // word offsets of the register port
   localparam int unsigned ADDR_W = 2;
   typedef enum logic [ADDR_W-1:0] {
      REG_STAT  = 2'd0,
      REG_MASKV = 2'd1,
      REG_ENA   = 2'd2,
      REG_DIS   = 2'd3
   } reg_sel_e;

   // event bit positions, shared by status and mask
   localparam int unsigned EV_DONE    = 0;
   localparam int unsigned EV_LEVEL   = 1;
   localparam int unsigned EV_NOACK   = 2;
   localparam int unsigned EV_TMO     = 3;
   localparam int unsigned EV_TGT_RDY = 4;
   localparam int unsigned EV_RX_OVF  = 5;
   localparam int unsigned EV_TX_OVF  = 6;
   localparam int unsigned EV_RX_UNF  = 7;
   localparam int unsigned EV_ARB     = 9;
endpackage

// File: rtl/evt_irq_sticky.sv
module evt_irq_sticky #(
   parameter int unsigned W    = 10,
   parameter logic [W-1:0] LIVE = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] stat_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (LIVE[i]) begin : g_live
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= 1'b0;
            else if (set_i[i]) q <= 1'b1;   // set wins over clear
            else if (clr_i[i]) q <= 1'b0;
         end
         assign stat_o[i] = q;
      end else begin : g_rsvd
         assign stat_o[i] = 1'b0;
      end
   end

   // R2
   evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |(set_i & LIVE) |=> ((stat_o & $past(set_i & LIVE)) == $past(set_i & LIVE)));
   // R3
   no_stray_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(stat_o) & ~$past(clr_i) & ~stat_o) == '0));
endmodule

// File: rtl/evt_irq_mask.sv
module evt_irq_mask #(
   parameter int unsigned W    = 10,
   parameter logic [W-1:0] LIVE = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] on_i,
   input  logic [W-1:0] off_i,
   output logic [W-1:0] mask_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (LIVE[i]) begin : g_live
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= 1'b0;
            else if (off_i[i]) q <= 1'b0;
            else if (on_i[i])  q <= 1'b1;
         end
         assign mask_o[i] = q;
      end else begin : g_rsvd
         assign mask_o[i] = 1'b0;
      end
   end

   // R5
   mask_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(on_i & LIVE) && off_i == '0) |=> ((mask_o & $past(on_i & LIVE)) == $past(on_i & LIVE)));
   // R6
   mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |off_i |=> ((mask_o & $past(off_i)) == '0));
   // R7
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (on_i == '0 && off_i == '0) |=> $stable(mask_o));
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
   import evt_irq_pkg::*;
#(
   parameter int unsigned EVT_W    = 10,
   parameter int unsigned DW       = 32,
   parameter logic [EVT_W-1:0] LIVE     = 10'h2FF,
   parameter logic [EVT_W-1:0] ERR_SET  = 10'h2E4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EVT_W-1:0]  evt_i,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              irq,
   output logic              err_any
);
   localparam int unsigned PAD_W = DW - EVT_W;

   if (EVT_W >= DW) begin : g_bad_width
      $error("evt_irq_regs: DW must exceed EVT_W");
   end
   if ((ERR_SET & ~LIVE) != '0) begin : g_bad_err
      $error("evt_irq_regs: error class names a reserved bit");
   end

   reg_sel_e         sel;
   logic [EVT_W-1:0] wbits, stat_clr, mask_on, mask_off;
   logic [EVT_W-1:0] stat, mask, rd_sel;

   assign sel      = reg_sel_e'(bus_addr);
   assign wbits    = bus_wdata[EVT_W-1:0];
   assign stat_clr = (bus_wr && sel == REG_STAT) ? wbits : '0;
   assign mask_on  = (bus_wr && sel == REG_ENA)  ? wbits : '0;
   assign mask_off = (bus_wr && sel == REG_DIS)  ? wbits : '0;

   evt_irq_sticky #(.W(EVT_W), .LIVE(LIVE)) u_sticky (
      .clk(clk), .rst_n(rst_n), .set_i(evt_i), .clr_i(stat_clr), .stat_o(stat)
   );

   evt_irq_mask #(.W(EVT_W), .LIVE(LIVE)) u_mask (
      .clk(clk), .rst_n(rst_n), .on_i(mask_on), .off_i(mask_off), .mask_o(mask)
   );

   always_comb begin
      unique case (sel)
         REG_STAT:  rd_sel = stat;
         REG_MASKV: rd_sel = mask;
         default:   rd_sel = '0;   // write-only strobes
      endcase
   end
   assign bus_rdata = {{PAD_W{1'b0}}, rd_sel};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |(stat & mask);
   end

   assign err_any = |(stat & ERR_SET);

   // R8
   irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == $past(|(stat & mask))));
   // R9
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat | mask) & ~LIVE) == '0);
   // R11
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DW-1:EVT_W] == '0);
   // R4
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |(evt_i & stat_clr & LIVE) |=> ((stat & $past(evt_i & stat_clr & LIVE)) != '0));
endmodule

// File: tb/evt_irq_regs_tb.sv
module evt_irq_regs_tb;
   localparam logic [9:0] LIVE = 10'h2FF;
   localparam logic [9:0] ERRS = 10'h2E4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  evt_i = '0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, err_any;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [9:0] m_stat = '0, m_mask = '0;
   logic       m_irq = 1'b0;

   always #2.5 clk = ~clk;

   evt_irq_regs u_dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .err_any(err_any)
   );

   function automatic logic [9:0] f_stat(logic [9:0] s, logic [9:0] ev, logic [9:0] clr);
      return ((s & ~clr) | ev) & LIVE;
   endfunction
   function automatic logic [9:0] f_mask(logic [9:0] m, logic [9:0] on, logic [9:0] off);
      return ((m | on) & ~off) & LIVE;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one clock: drive at negedge, model the edge, return at next negedge
   task automatic cyc(input logic [9:0] ev, input bit wr, input logic [1:0] a, input logic [31:0] d);
      logic [9:0] clr, on, off;
      evt_i = ev; bus_wr = wr; bus_addr = a; bus_wdata = d;
      clr = (wr && a == 2'd0) ? d[9:0] : '0;
      on  = (wr && a == 2'd2) ? d[9:0] : '0;
      off = (wr && a == 2'd3) ? d[9:0] : '0;
      @(posedge clk);
      m_irq  = |(m_stat & m_mask);
      m_stat = f_stat(m_stat, ev, clr);
      m_mask = f_mask(m_mask, on, off);
      @(negedge clk);
      evt_i = '0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
      bus_addr = a;
      #0.5;
      chk(bus_rdata === exp, tag, bus_rdata, exp);
   endtask

   task automatic chk_all(input string tag);
      rd(2'd0, {22'd0, m_stat}, {tag, " R2 R3 status"});
      rd(2'd1, {22'd0, m_mask}, {tag, " R5 R6 mask"});
      chk(irq === m_irq, {tag, " R8 irq"}, irq, m_irq);
      chk(err_any === |(m_stat & ERRS), {tag, " R10 err_any"}, err_any, |(m_stat & ERRS));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd7321));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(2'd0, 32'd0, "R1 status after reset");
      rd(2'd1, 32'd0, "R1 mask after reset");
      chk(irq === 1'b0, "R1 irq after reset", irq, 0);

      // R2 event with mask clear latches, no irq
      cyc(10'h005, 0, 0, 0);
      cyc(10'h000, 0, 0, 0);
      rd(2'd0, 32'h005, "R2 status latched unmasked");
      chk(irq === 1'b0, "R2 irq stays low while masked", irq, 0);
      chk(err_any === 1'b1, "R10 nack pending raises err_any", err_any, 1);

      // R5 enable sets bit 0 only; irq follows one edge later (R8)
      cyc(10'h000, 1, 2, 32'h001);
      rd(2'd1, 32'h001, "R5 mask after enable");
      rd(2'd2, 32'h000, "R5 enable offset reads zero");
      chk(irq === 1'b0, "R8 irq not yet high", irq, 0);
      cyc(10'h000, 0, 0, 0);
      chk(irq === 1'b1, "R8 irq high one edge after enable", irq, 1);

      // R3 clear bit 0 only
      cyc(10'h000, 1, 0, 32'h001);
      rd(2'd0, 32'h004, "R3 only written-one bit cleared");
      chk(err_any === 1'b1, "R10 err_any holds", err_any, 1);
      cyc(10'h000, 0, 0, 0);
      chk(irq === 1'b0, "R8 irq drops after clear", irq, 0);

      // R4 set and clear on same bit
      cyc(10'h008, 1, 0, 32'h00C);
      rd(2'd0, 32'h008, "R4 set wins, other bit cleared");
      chk(err_any === 1'b0, "R10 no error bits pending", err_any, 0);

      // R7 write to mask view ignored
      cyc(10'h000, 1, 1, 32'h3FF);
      rd(2'd1, 32'h001, "R7 mask unchanged by view write");
      rd(2'd0, 32'h008, "R7 status unchanged by view write");

      // R6 disable clears selected bit only
      cyc(10'h000, 1, 2, 32'h208);
      cyc(10'h000, 1, 3, 32'h001);
      rd(2'd1, 32'h208, "R6 mask after disable");
      rd(2'd3, 32'h000, "R6 disable offset reads zero");

      // R9 reserved bit 8
      cyc(10'h100, 1, 2, 32'h100);
      rd(2'd0, 32'h008, "R9 reserved status bit stays zero");
      rd(2'd1, 32'h208, "R9 reserved mask bit stays zero");

      // R10 arbitration lost is error class
      cyc(10'h200, 0, 0, 0);
      chk(err_any === 1'b1, "R10 arbitration pending", err_any, 1);

      // R11 upper read bits
      cyc(10'h000, 1, 0, 32'hFFFF_FFFF);
      cyc(10'h3FF, 1, 2, 32'hFFFF_FFFF);
      rd(2'd0, 32'h2FF, "R11 status readback pad zero");
      rd(2'd1, 32'h2FF, "R11 mask readback pad zero");

      // random mix
      for (int n = 0; n < 3000; n++) begin
         logic [9:0] ev;
         logic [31:0] d;
         int r;
         ev = ($urandom % 4 == 0) ? 10'($urandom) : '0;
         d  = $urandom;
         r  = $urandom % 3;
         cyc(ev, r != 0, 2'($urandom), d);
         chk_all("RAND");
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule